// File: doc/BRIEF.md
# Masked Any-Field Calendar Alarm

This block watches a calendar time that is kept elsewhere and raises an alarm interrupt when the time agrees with a programmed alarm setting. The timekeeper supplies a one-cycle strobe each second, in the same cycle as the newly advanced BCD time. On that strobe the block compares each alarm field with the matching time field: seconds, minutes, hours, day of month, month and a three-digit BCD year.

A per-field enable mask chooses which fields take part in the comparison. The enabled results are combined with a logical OR, so agreement on any one enabled field is enough to fire. A global enable bit gates every comparison. A firing alarm sets a sticky status flag, and the level interrupt output follows that flag until software clears it by writing one to it.

Software reaches the block through a simple register port: one write port with address, data and a write enable, and a separate read address that drives combinational read data. Each alarm register keeps only the width its field needs. Wider writes are truncated, and reads return the stored value zero-extended.

Top module: `alarm_any`

## Requirements
- R1: After reset every alarm register, the enable register and the status flag read as zero, and `alarm_irq` is low.
- R2: Register addresses are 0 status, 1 enable, 2 seconds, 3 minutes, 4 hours, 5 day of month, 6 month and 7 year. Seconds and minutes keep 7 bits, hours and day keep 6, month keeps 5, year keeps 12, and the enable register keeps 7. Wider write data is truncated, and reads return the stored bits zero-extended.
- R3: While enable bit 6 (global enable) is clear, no strobe sets the flag, whatever the field matches.
- R4: Enable bits 0 to 5 select seconds, minutes, hours, day, month and year in that order. A field whose bit is clear has no effect, even when it matches.
- R5: With global enable set, a strobe on which at least one enabled field equals its alarm register sets the flag. One matching field is sufficient.
- R6: The comparison takes place only in a cycle with `sec_tick` high, using the register values held before that clock edge. The flag, and with it `alarm_irq`, is high from the edge that samples the strobe onward.
- R7: The year is compared as all 12 bits: tens and units in bits [7:0] and the hundreds digit in bits [11:8]. A difference in the hundreds digit alone prevents a year match.
- R8: Writing address 0 with data bit 1 set clears the flag and `alarm_irq` at the next edge. Writing address 0 with bit 1 clear has no effect. A firing strobe in the same cycle as a clear leaves the flag set. The status register reads the flag at bit 1 and zero elsewhere.
- R9: The flag is sticky: once set it stays set, and `alarm_irq` stays high, until it is cleared through R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| sec_tick | input | 1 | One-cycle strobe, once per second, after the time has advanced |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_mday | input | 8 | Current day of month, BCD |
| now_mon | input | 8 | Current month, BCD |
| now_year | input | 12 | Current year, three BCD digits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Read data for `rd_addr`, combinational |
| alarm_irq | output | 1 | Level alarm interrupt, equal to the sticky flag |

## Verification
The assertions assume three things: `rst_n` is released away from the clock edge, `sec_tick` lasts one cycle per event, and the time inputs are stable in the strobe cycle. The stimulus drives every input shortly after a rising edge and holds it for the whole cycle. Strobes are always single-cycle. The randomized phase keeps time and alarm values within a few codes, so that matches occur often. It also sets high bits in the write data to exercise truncation, and it lets status clears and firing strobes fall in the same cycle.

// File: rtl/alarm_any_pkg.sv
package alarm_any_pkg;
  localparam int NFIELD    = 6;
  localparam int FIELD_W   = 12;
  localparam int ADDR_W    = 3;
  localparam int EN_W      = 7;
  localparam int GLOBAL_EN = 6;
  localparam int FLAG_BIT  = 1;
  localparam int FIELD_BASE = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 3'd0,
    A_EN   = 3'd1,
    A_SEC  = 3'd2,
    A_MIN  = 3'd3,
    A_HOUR = 3'd4,
    A_MDAY = 3'd5,
    A_MON  = 3'd6,
    A_YEAR = 3'd7
  } reg_addr_e;

  typedef logic [NFIELD-1:0][FIELD_W-1:0] field_vec_t;

  function automatic int field_width(input int idx);
    case (idx)
      0, 1:    field_width = 7;
      2, 3:    field_width = 6;
      4:       field_width = 5;
      default: field_width = 12;
    endcase
  endfunction
endpackage

// File: rtl/alarm_any_regs.sv
module alarm_any_regs
  import alarm_any_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [EN_W-1:0]   en_q,
  output field_vec_t        alarm_q
);
  logic          en_ld;
  logic [EN_W-1:0] en_d;

  always_comb begin
    en_ld = wr_en && (wr_addr == A_EN);
    en_d  = wr_data[EN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ld) en_q <= en_d;
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    localparam int W = field_width(g);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(FIELD_BASE + g);
    logic         ld;
    logic [W-1:0] d;
    logic [W-1:0] q;

    always_comb begin
      ld = wr_en && (wr_addr == MY_ADDR);
      d  = wr_data[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
    end

    assign alarm_q[g] = FIELD_W'(q);

    AST_WRITE_TRUNC: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == MY_ADDR) |=>
        (alarm_q[g] == FIELD_W'($past(wr_data[W-1:0])))); // R2
  end
endmodule

// File: rtl/alarm_any_match.sv
module alarm_any_match
  import alarm_any_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EN_W-1:0]   en_q,
  input  field_vec_t        alarm_q,
  input  field_vec_t        now_v,
  output logic              any_hit
);
  logic [NFIELD-1:0] eq;
  logic [NFIELD-1:0] sel;

  for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
    assign eq[g] = (now_v[g] == alarm_q[g]);
  end

  always_comb begin
    sel     = en_q[NFIELD-1:0] & eq;
    any_hit = en_q[GLOBAL_EN] && (|sel);
  end

  AST_HIT_SINGLE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[GLOBAL_EN] && en_q[0] && now_v[0] == alarm_q[0]) |-> any_hit); // R5
endmodule

// File: rtl/alarm_any_flag.sv
module alarm_any_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = set | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q); // R9
  AST_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set)); // R6
endmodule

// File: rtl/alarm_any.sv
module alarm_any
  import alarm_any_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic [7:0]        now_sec,
  input  logic [7:0]        now_min,
  input  logic [7:0]        now_hour,
  input  logic [7:0]        now_mday,
  input  logic [7:0]        now_mon,
  input  logic [11:0]       now_year,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              alarm_irq
);
  logic [EN_W-1:0] en_q;
  field_vec_t      alarm_q;
  field_vec_t      now_v;
  logic            any_hit;
  logic            flag_set;
  logic            flag_clr;
  logic            flag_q;

  always_comb begin
    now_v[0] = FIELD_W'(now_sec);
    now_v[1] = FIELD_W'(now_min);
    now_v[2] = FIELD_W'(now_hour);
    now_v[3] = FIELD_W'(now_mday);
    now_v[4] = FIELD_W'(now_mon);
    now_v[5] = now_year;
  end

  alarm_any_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en_q    (en_q),
    .alarm_q (alarm_q)
  );

  alarm_any_match u_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_q    (en_q),
    .alarm_q (alarm_q),
    .now_v   (now_v),
    .any_hit (any_hit)
  );

  always_comb begin
    flag_set = sec_tick && any_hit;
    flag_clr = wr_en && (wr_addr == A_STAT) && wr_data[FLAG_BIT];
  end

  alarm_any_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (flag_set),
    .clr    (flag_clr),
    .flag_q (flag_q)
  );

  assign alarm_irq = flag_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_STAT:  rd_data[FLAG_BIT] = flag_q;
      A_EN:    rd_data[EN_W-1:0] = en_q;
      default: rd_data[FIELD_W-1:0] = alarm_q[int'(rd_addr) - FIELD_BASE];
    endcase
  end

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[GLOBAL_EN] && !alarm_irq) |=> !alarm_irq); // R3
  AST_NO_TICK_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !alarm_irq) |=> !alarm_irq); // R6
  AST_YEAR_HUNDREDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !alarm_irq && en_q == 7'h60 &&
     now_year[11:8] != alarm_q[5][11:8]) |=> !alarm_irq); // R7
endmodule

// File: tb/alarm_any_test.sv
module alarm_any_test;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_mday = '0, now_mon = '0;
  logic [11:0] now_year = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic alarm_irq;

  int n_run = 0, n_fail = 0, cyc_cnt = 0;
  int mreg [0:7];
  bit mflag = 0;

  always #4 clk = ~clk;

  alarm_any #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_mday(now_mday), .now_mon(now_mon), .now_year(now_year),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .alarm_irq(alarm_irq));

  function automatic int keep_mask(int a);
    case (a)
      1, 2, 3: return 'h7f;
      4, 5:    return 'h3f;
      6:       return 'h1f;
      default: return 'hfff;
    endcase
  endfunction

  function automatic int now_of(int g);
    case (g)
      0: return int'(now_sec);
      1: return int'(now_min);
      2: return int'(now_hour);
      3: return int'(now_mday);
      4: return int'(now_mon);
      default: return int'(now_year);
    endcase
  endfunction

  function automatic int expect_rd(int a);
    if (a == 0) return mflag ? 2 : 0;
    return mreg[a];
  endfunction

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: model follows the edge, then outputs are compared
  task automatic tick(string tag);
    bit hit, setf, clrf;
    @(posedge clk);
    hit = 0;
    if (mreg[1][6]) begin
      for (int g = 0; g < 6; g++)
        if (mreg[1][g] && now_of(g) == mreg[g + 2]) hit = 1;
    end
    setf = sec_tick && hit;
    clrf = wr_en && wr_addr == 0 && wr_data[1];
    mflag = setf || (mflag && !clrf);
    if (wr_en && wr_addr != 0) mreg[wr_addr] = int'(wr_data) & keep_mask(int'(wr_addr));
    #2;
    check(tag, int'(alarm_irq), int'(mflag));
    check(tag, int'(rd_data), expect_rd(int'(rd_addr)));
    wr_en = 0;
    sec_tick = 0;
  endtask

  task automatic wr(int a, int d, string tag);
    wr_en = 1; wr_addr = 3'(a); wr_data = DW'(d); rd_addr = 3'(a);
    tick(tag);
  endtask

  task automatic pulse(int s, int mi, int h, int dy, int mo, int y, string tag);
    sec_tick = 1; now_sec = 8'(s); now_min = 8'(mi); now_hour = 8'(h);
    now_mday = 8'(dy); now_mon = 8'(mo); now_year = 12'(y); rd_addr = 0;
    tick(tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mreg[i] = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: reset values at every address
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      check("R1", int'(rd_data), 0);
    end
    check("R1", int'(alarm_irq), 0);

    // R2: truncation and read back
    wr(1, 'hff80, "R2");
    wr(2, 'hffb0, "R2"); wr(3, 'h00d9, "R2"); wr(4, 'h00e3, "R2");
    wr(5, 'h00f1, "R2"); wr(6, 'h00f2, "R2"); wr(7, 'hf123, "R2");
    for (int a = 1; a < 8; a++) begin
      rd_addr = 3'(a); tick("R2");
    end

    // R3: global enable off, seconds enabled and matching
    wr(1, 'h01, "R3");
    pulse('h30, 0, 0, 0, 0, 0, "R3");
    // R6: match present but no strobe
    wr(1, 'h41, "R6");
    now_sec = 8'h30; rd_addr = 0; tick("R6");
    // R5/R6: single enabled field fires on strobe
    pulse('h30, 0, 0, 0, 0, 0, "R5");
    // R9: sticky across a non-matching strobe and idle cycles
    pulse('h31, 0, 0, 0, 0, 0, "R9");
    tick("R9"); tick("R9");
    // R8: write with bit 1 clear has no effect, then clear
    wr(0, 'hfffd, "R8");
    wr(0, 'h0002, "R8");
    // R4: seconds matches but only minutes enabled
    wr(1, 'h42, "R4");
    pulse('h30, 'h00, 0, 0, 0, 0, "R4");
    // R5: minutes alone fires, other enabled fields mismatching
    wr(1, 'h7f, "R5");
    pulse('h00, 'h59, 0, 0, 0, 0, "R5");
    wr(0, 2, "R8");
    // R7: hundreds digit differs
    wr(1, 'h60, "R7");
    pulse(0, 0, 0, 0, 0, 'h023, "R7");
    pulse(0, 0, 0, 0, 0, 'h123, "R7");
    // R8: clear and firing strobe in the same cycle, set wins
    wr_en = 1; wr_addr = 0; wr_data = 2;
    pulse(0, 0, 0, 0, 0, 'h123, "R8");
    wr(0, 2, "R8");

    // randomized mix, model compared every clock
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1; wr_addr = 3'($urandom_range(0, 7));
        if (wr_addr == 1) wr_data = DW'($urandom);
        else wr_data = DW'($urandom_range(0, 3)) | ($urandom_range(0, 1) ? 16'hf000 : 16'h0);
      end
      sec_tick = ($urandom_range(0, 2) == 0);
      now_sec = 8'($urandom_range(0, 3)); now_min = 8'($urandom_range(0, 3));
      now_hour = 8'($urandom_range(0, 3)); now_mday = 8'($urandom_range(0, 3));
      now_mon = 8'($urandom_range(0, 3)); now_year = 12'($urandom_range(0, 3));
      rd_addr = 3'($urandom_range(0, 7));
      tick("R5");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc_cnt);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule